// File: doc/BRIEF.md
# Serial Link Start-Up Sequencer

This block is the master-side controller that takes a low-swing serial link from a powered-down state to a running line clock. While the active-low power-down input is held low, the clock line and data lines are left undriven, so they draw no current, and the PLL enable is off. When power-down is released, the block turns on the PLL enable and waits a fixed number of reference cycles for lock. It then plays a three-segment calibration preamble that lets the far end trim its receivers: clock line low, then clock line high, then clock and data lines both low. After the preamble it runs a free line clock for as long as power-down stays released.

Once the clock runs, the link rests in IDLE with every data line driven high. A transfer request moves it into ACTIVE. In ACTIVE the data lines carry the caller's bits, and the caller supplies the high start bit and all framing. Dropping the request returns the link to IDLE. A 2-bit phase code reports where the link is. A single-cycle ready pulse marks the first IDLE cycle after each bring-up. The line clock is derived from the reference clock: it toggles every `CLK_HALF` reference cycles, so one link clock cycle lasts `2*CLK_HALF` reference cycles.

Top module: `linkup_seq`

## Requirements
- R1: While `rstN` is low, or while `pwrDownN` has been sampled low, the outputs hold these values: `phase` = 0 (OFF), `pllEnable` = 0, `clkLineEn` = 0, `dataLineEn` all 0, `clkLineLvl` = 0, `dataLineLvl` all 0.
- R2: If `pwrDownN` is sampled low on an edge, the block is in OFF (phase 0) from that edge, whatever phase it was in. All progress is discarded, so the next release replays the lock wait and every segment at full length.
- R3: On the first edge at which `pwrDownN` is sampled high in OFF, `pllEnable` goes to 1. For the next `LOCK_CYCLES` cycles (default 4096) the phase stays 0 and all line enables stay 0.
- R4: Calibration segment 1 follows the lock wait and lasts `SEG_CYCLES*2*CLK_HALF` reference cycles (180 link clocks, 720 reference cycles by default). In it, `phase` = 1 (LINK-UP), `clkLineEn` = 1, `clkLineLvl` = 0 and `dataLineEn` = 0.
- R5: Segment 2 follows for the same length, with `phase` = 1, `clkLineEn` = 1, `clkLineLvl` = 1 and `dataLineEn` = 0.
- R6: Segment 3 follows for the same length, with `phase` = 1, `clkLineEn` = 1, `clkLineLvl` = 0, every `dataLineEn` bit 1 and every `dataLineLvl` bit 0.
- R7: After segment 3, `clkLineEn` = 1 and `clkLineLvl` is 0 for the first `CLK_HALF` cycles. It then inverts every `CLK_HALF` cycles without a break, through IDLE and ACTIVE alike.
- R8: In IDLE (`phase` = 2), every `dataLineEn` bit is 1 and every `dataLineLvl` bit is 1.
- R9: `linkReady` is 1 in exactly one cycle per bring-up, the first IDLE cycle after segment 3, and is 0 on returning to IDLE from ACTIVE.
- R10: A high `xferReq` sampled in IDLE moves the block to ACTIVE (`phase` = 3, `xferAck` = 1) on that edge. In ACTIVE, `dataLineLvl` follows `txData` in the same cycle. A low `xferReq` sampled in ACTIVE returns it to IDLE on that edge.
- R11: `xferReq` has no effect in OFF, during the lock wait or during any calibration segment: the phase code and line outputs follow R1 and R3 to R6 as if it were low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwrDownN | input | 1 | Power-down, active low; high releases the link |
| xferReq | input | 1 | Request to enter ACTIVE |
| txData | input | NUM_DATA | Data line levels to drive in ACTIVE |
| pllEnable | output | 1 | Enable to the PLL |
| clkLineEn | output | 1 | Clock line driver enable (0 = no current) |
| clkLineLvl | output | 1 | Logic level on the clock line |
| dataLineEn | output | NUM_DATA | Data line driver enables (0 = no current) |
| dataLineLvl | output | NUM_DATA | Logic levels on the data lines |
| phase | output | 2 | 0 OFF, 1 LINK-UP, 2 IDLE, 3 ACTIVE |
| linkReady | output | 1 | One-cycle pulse on first IDLE after bring-up |
| xferAck | output | 1 | High while in ACTIVE |

## Verification
The bench aims at segment boundaries. A counter that is off by one would move the clock line's low-to-high step or the data-line enable by a cycle. Power-down is dropped in the middle of segment 2, during the lock wait, and for a single cycle in IDLE. A design that kept its counter or its line-clock divider across power-down would shorten the next preamble or start the free clock in the wrong phase. A request held through the whole link-up and a request pulsed mid-calibration check that ACTIVE is entered only from IDLE: a leaky design would show phase 3 early or skip segments. The bench also returns from ACTIVE to IDLE and watches that `linkReady` does not pulse again.

// File: rtl/linkup_pkg.sv
package linkup_pkg;

  typedef enum logic [1:0] {
    PH_OFF    = 2'd0,
    PH_LINKUP = 2'd1,
    PH_IDLE   = 2'd2,
    PH_ACTIVE = 2'd3
  } phase_e;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_LOCK,
    ST_SEG1,
    ST_SEG2,
    ST_SEG3,
    ST_IDLE,
    ST_ACTIVE
  } seq_state_e;

  // Line drive pattern requested by the control FSM
  typedef enum logic [2:0] {
    LM_QUIET,
    LM_CAL_LO,
    LM_CAL_HI,
    LM_CAL_ALL_LO,
    LM_RUN_IDLE,
    LM_RUN_XFER
  } line_mode_e;

  typedef struct packed {
    line_mode_e mode;
    logic       lockWait;  // counter limit selects the lock wait
    logic       cntRun;    // counter advances this cycle
    logic       cntClr;    // counter restarts at zero
  } seq_strobe_t;

endpackage

// File: rtl/linkup_ctrl.sv
module linkup_ctrl
  import linkup_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwrDownN,
  input  logic        xferReq,
  input  logic        cntDone,
  output seq_strobe_t strobe,
  output logic        pllEnable,
  output logic [1:0]  phase,
  output logic        linkReady,
  output logic        xferAck
);

  seq_state_e state, nextState;
  logic       readyQ;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_OFF:    if (pwrDownN) nextState = ST_LOCK;
      ST_LOCK:   if (cntDone)  nextState = ST_SEG1;
      ST_SEG1:   if (cntDone)  nextState = ST_SEG2;
      ST_SEG2:   if (cntDone)  nextState = ST_SEG3;
      ST_SEG3:   if (cntDone)  nextState = ST_IDLE;
      ST_IDLE:   if (xferReq)  nextState = ST_ACTIVE;
      ST_ACTIVE: if (!xferReq) nextState = ST_IDLE;
      default:                 nextState = ST_OFF;
    endcase
    if (!pwrDownN) nextState = ST_OFF;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_OFF;
      readyQ <= 1'b0;
    end else begin
      state  <= nextState;
      readyQ <= (state == ST_SEG3) && (nextState == ST_IDLE);
    end
  end

  always_comb begin
    strobe.lockWait = (state == ST_LOCK);
    strobe.cntRun   = (state == ST_LOCK) || (state == ST_SEG1) ||
                      (state == ST_SEG2) || (state == ST_SEG3);
    strobe.cntClr   = (nextState != state);
    unique case (state)
      ST_SEG1:   strobe.mode = LM_CAL_LO;
      ST_SEG2:   strobe.mode = LM_CAL_HI;
      ST_SEG3:   strobe.mode = LM_CAL_ALL_LO;
      ST_IDLE:   strobe.mode = LM_RUN_IDLE;
      ST_ACTIVE: strobe.mode = LM_RUN_XFER;
      default:   strobe.mode = LM_QUIET;
    endcase
  end

  always_comb begin
    unique case (state)
      ST_SEG1, ST_SEG2, ST_SEG3: phase = PH_LINKUP;
      ST_IDLE:                   phase = PH_IDLE;
      ST_ACTIVE:                 phase = PH_ACTIVE;
      default:                   phase = PH_OFF;
    endcase
  end

  assign pllEnable = (state != ST_OFF);
  assign xferAck   = (state == ST_ACTIVE);
  assign linkReady = readyQ;

  // R2: a sampled power-down always lands in OFF with the PLL disabled
  a_r2_powerdown_off: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDownN |=> (phase == PH_OFF) && !pllEnable);

  // R9: the ready pulse only follows the calibration preamble
  a_r9_ready_after_cal: assert property (@(posedge clk) disable iff (!rstN)
    linkReady |-> (phase == PH_IDLE) && ($past(phase) == PH_LINKUP));

  // R10: ACTIVE is entered only from IDLE with a request present
  a_r10_ack_from_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferAck) |-> ($past(phase) == PH_IDLE) && $past(xferReq));

  // R11: outside IDLE/ACTIVE the next phase is never ACTIVE
  a_r11_no_early_active: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_OFF || phase == PH_LINKUP) |=> (phase != PH_ACTIVE));

  // R4: link-up only leaves towards IDLE or OFF
  a_r4_linkup_exit: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_LINKUP) |=> (phase == PH_LINKUP || phase == PH_IDLE || phase == PH_OFF));

endmodule

// File: rtl/linkup_datapath.sv
module linkup_datapath
  import linkup_pkg::*;
#(
  parameter int LOCK_CYCLES = 4096,
  parameter int SEG_REF     = 720,
  parameter int CLK_HALF    = 2,
  parameter int NUM_DATA    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  seq_strobe_t         strobe,
  input  logic [NUM_DATA-1:0] txData,
  output logic                cntDone,
  output logic                clkLineEn,
  output logic                clkLineLvl,
  output logic [NUM_DATA-1:0] dataLineEn,
  output logic [NUM_DATA-1:0] dataLineLvl
);

  localparam int CNT_MAX = (LOCK_CYCLES > SEG_REF) ? LOCK_CYCLES : SEG_REF;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int DIV_W   = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam logic [CNT_W-1:0] LOCK_LAST = CNT_W'(LOCK_CYCLES - 1);
  localparam logic [CNT_W-1:0] SEG_LAST  = CNT_W'(SEG_REF - 1);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(CLK_HALF - 1);

  logic [CNT_W-1:0] segCnt;
  logic [DIV_W-1:0] divCnt;
  logic             runClk;
  logic             running;

  // Shared segment / lock-wait counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              segCnt <= '0;
    else if (strobe.cntClr) segCnt <= '0;
    else if (strobe.cntRun) segCnt <= segCnt + 1'b1;
  end

  assign cntDone = strobe.cntRun &&
                   (segCnt == (strobe.lockWait ? LOCK_LAST : SEG_LAST));

  // Free-running line clock derived from the reference clock
  assign running = (strobe.mode == LM_RUN_IDLE) || (strobe.mode == LM_RUN_XFER);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      runClk <= 1'b0;
    end else if (!running) begin
      divCnt <= '0;
      runClk <= 1'b0;
    end else if (divCnt == DIV_LAST) begin
      divCnt <= '0;
      runClk <= ~runClk;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // Clock line drive
  always_comb begin
    unique case (strobe.mode)
      LM_CAL_LO, LM_CAL_ALL_LO: begin clkLineEn = 1'b1; clkLineLvl = 1'b0;   end
      LM_CAL_HI:                begin clkLineEn = 1'b1; clkLineLvl = 1'b1;   end
      LM_RUN_IDLE, LM_RUN_XFER: begin clkLineEn = 1'b1; clkLineLvl = runClk; end
      default:                  begin clkLineEn = 1'b0; clkLineLvl = 1'b0;   end
    endcase
  end

  // Per-lane data line drive
  for (genvar lane = 0; lane < NUM_DATA; lane++) begin : g_lane
    always_comb begin
      unique case (strobe.mode)
        LM_CAL_ALL_LO: begin dataLineEn[lane] = 1'b1; dataLineLvl[lane] = 1'b0;         end
        LM_RUN_IDLE:   begin dataLineEn[lane] = 1'b1; dataLineLvl[lane] = 1'b1;         end
        LM_RUN_XFER:   begin dataLineEn[lane] = 1'b1; dataLineLvl[lane] = txData[lane]; end
        default:       begin dataLineEn[lane] = 1'b0; dataLineLvl[lane] = 1'b0;         end
      endcase
    end
  end

  // R1: a quiet mode leaves every line undriven
  a_r1_quiet_lines: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mode == LM_QUIET) |-> !clkLineEn && (dataLineEn == '0) && !clkLineLvl);

  // R8: idle holds every data line driven high
  a_r8_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mode == LM_RUN_IDLE) |-> (&dataLineLvl) && (&dataLineEn));

  // R7: the line clock starts low on entry to the running modes
  a_r7_run_starts_low: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobe.mode) == LM_CAL_ALL_LO && running) |-> !clkLineLvl);

  // R3: the counter never runs past its active limit
  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntRun |-> (segCnt <= (strobe.lockWait ? LOCK_LAST : SEG_LAST)));

endmodule

// File: rtl/linkup_seq.sv
module linkup_seq
  import linkup_pkg::*;
#(
  parameter int LOCK_CYCLES = 4096,
  parameter int SEG_CYCLES  = 180,
  parameter int CLK_HALF    = 2,
  parameter int NUM_DATA    = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                pwrDownN,
  input  logic                xferReq,
  input  logic [NUM_DATA-1:0] txData,
  output logic                pllEnable,
  output logic                clkLineEn,
  output logic                clkLineLvl,
  output logic [NUM_DATA-1:0] dataLineEn,
  output logic [NUM_DATA-1:0] dataLineLvl,
  output logic [1:0]          phase,
  output logic                linkReady,
  output logic                xferAck
);

  localparam int SEG_REF = SEG_CYCLES * 2 * CLK_HALF;

  seq_strobe_t strobe;
  logic        cntDone;

  linkup_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pwrDownN  (pwrDownN),
    .xferReq   (xferReq),
    .cntDone   (cntDone),
    .strobe    (strobe),
    .pllEnable (pllEnable),
    .phase     (phase),
    .linkReady (linkReady),
    .xferAck   (xferAck)
  );

  linkup_datapath #(
    .LOCK_CYCLES (LOCK_CYCLES),
    .SEG_REF     (SEG_REF),
    .CLK_HALF    (CLK_HALF),
    .NUM_DATA    (NUM_DATA)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .txData      (txData),
    .cntDone     (cntDone),
    .clkLineEn   (clkLineEn),
    .clkLineLvl  (clkLineLvl),
    .dataLineEn  (dataLineEn),
    .dataLineLvl (dataLineLvl)
  );

endmodule

// File: tb/linkup_seq_tb.sv
module linkup_seq_tb;

  localparam int L  = 4096;
  localparam int SC = 180;
  localparam int CH = 2;
  localparam int ND = 2;
  localparam int S  = SC * 2 * CH;
  localparam int RUN0 = L + 3 * S;

  logic          clk = 1'b0;
  logic          rstN;
  logic          pwrDownN;
  logic          xferReq;
  logic [ND-1:0] txData;
  logic          pllEnable, clkLineEn, clkLineLvl, linkReady, xferAck;
  logic [ND-1:0] dataLineEn, dataLineLvl;
  logic [1:0]    phase;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // behavioural reference state
  int upTime = -1;   // cycles since leaving OFF, -1 when off
  bit act    = 1'b0;

  always #4 clk = ~clk;

  linkup_seq #(.LOCK_CYCLES(L), .SEG_CYCLES(SC), .CLK_HALF(CH), .NUM_DATA(ND)) u_dut (
    .clk(clk), .rstN(rstN), .pwrDownN(pwrDownN), .xferReq(xferReq), .txData(txData),
    .pllEnable(pllEnable), .clkLineEn(clkLineEn), .clkLineLvl(clkLineLvl),
    .dataLineEn(dataLineEn), .dataLineLvl(dataLineLvl), .phase(phase),
    .linkReady(linkReady), .xferAck(xferAck)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] actual, input logic [31:0] expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h",
               tag, what, cycles, actual, expected);
    end
  endtask

  // reference model update at the active edge
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      upTime = -1;
      act    = 1'b0;
    end else if (!pwrDownN) begin
      upTime = -1;
      act    = 1'b0;
    end else begin
      if (upTime >= RUN0) begin
        if (!act && xferReq)     act = 1'b1;
        else if (act && !xferReq) act = 1'b0;
      end
      upTime++;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [1:0]    ePh;
      logic          ePll, eCEn, eCLv, eRdy, eAck;
      logic [ND-1:0] eDEn, eDLv;
      string         tag;
      ePll = (upTime >= 0);
      eRdy = 1'b0; eAck = 1'b0;
      if (upTime < L) begin
        ePh = 2'd0; eCEn = 1'b0; eCLv = 1'b0; eDEn = '0; eDLv = '0;
        tag = (upTime < 0) ? "R1" : "R3";
      end else if (upTime < L + S) begin
        ePh = 2'd1; eCEn = 1'b1; eCLv = 1'b0; eDEn = '0; eDLv = '0; tag = "R4";
      end else if (upTime < L + 2 * S) begin
        ePh = 2'd1; eCEn = 1'b1; eCLv = 1'b1; eDEn = '0; eDLv = '0; tag = "R5";
      end else if (upTime < RUN0) begin
        ePh = 2'd1; eCEn = 1'b1; eCLv = 1'b0; eDEn = '1; eDLv = '0; tag = "R6";
      end else begin
        int r;
        r    = upTime - RUN0;
        eCEn = 1'b1;
        eCLv = ((r / CH) % 2) == 1;
        eDEn = '1;
        eRdy = (r == 0);
        eAck = act;
        ePh  = act ? 2'd3 : 2'd2;
        eDLv = act ? txData : '1;
        tag  = act ? "R10" : "R8";
      end
      chk(phase == ePh,          tag,   "phase",      32'(phase),       32'(ePh));
      chk(pllEnable == ePll,     "R3",  "pllEnable",  32'(pllEnable),   32'(ePll));
      chk(clkLineEn == eCEn,     tag,   "clkLineEn",  32'(clkLineEn),   32'(eCEn));
      chk(clkLineLvl == eCLv,    "R7",  "clkLineLvl", 32'(clkLineLvl),  32'(eCLv));
      chk(dataLineEn == eDEn,    tag,   "dataLineEn", 32'(dataLineEn),  32'(eDEn));
      chk(dataLineLvl == eDLv,   tag,   "dataLineLvl",32'(dataLineLvl), 32'(eDLv));
      chk(linkReady == eRdy,     "R9",  "linkReady",  32'(linkReady),   32'(eRdy));
      chk(xferAck == eAck,       "R10", "xferAck",    32'(xferAck),     32'(eAck));
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cycles > 150000 && !done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cycles);
      finish_run();
    end
  end

  initial begin
    rstN = 1'b0; pwrDownN = 1'b0; xferReq = 1'b0; txData = '0;
    wait_cycles(5);
    // R1: reset state
    chk(phase == 2'd0 && !pllEnable && !clkLineEn && dataLineEn == '0, "R1", "reset outputs",
        {26'd0, phase, pllEnable, clkLineEn, dataLineEn}, 32'd0);
    rstN = 1'b1;
    wait_cycles(20);                           // R1: held in OFF

    // first bring-up, request pulsed mid-calibration (R11)
    pwrDownN = 1'b1;
    wait_cycles(L + S + 10);
    xferReq = 1'b1;
    wait_cycles(20);
    xferReq = 1'b0;
    wait_cycles(2 * S + 100);                  // R8/R9 idle with ready pulse seen

    // transfers (R10)
    txData = 2'b10; xferReq = 1'b1;
    wait_cycles(10);
    txData = 2'b01;
    wait_cycles(10);
    xferReq = 1'b0;
    wait_cycles(20);                           // back to idle, no second ready pulse (R9)

    // power-down while ACTIVE (R2)
    xferReq = 1'b1;
    wait_cycles(5);
    pwrDownN = 1'b0;
    wait_cycles(10);
    xferReq = 1'b0;

    // power-down mid segment 2 then full restart (R2), request held through link-up (R11)
    pwrDownN = 1'b1;
    wait_cycles(L + S + 100);
    pwrDownN = 1'b0;
    wait_cycles(3);
    pwrDownN = 1'b1;
    xferReq = 1'b1; txData = 2'b11;
    wait_cycles(RUN0 + 20);
    xferReq = 1'b0;
    wait_cycles(10);

    // single-cycle power-down in IDLE, then one during the lock wait (R2)
    pwrDownN = 1'b0;
    wait_cycles(1);
    pwrDownN = 1'b1;
    wait_cycles(100);
    pwrDownN = 1'b0;
    wait_cycles(2);
    pwrDownN = 1'b1;
    wait_cycles(RUN0 + 50);
    finish_run();
  end

endmodule